// File: doc/BRIEF.md
# Miss Target Queue with Upgrade Rewrite

This block holds the requests that wait on one outstanding cache miss. Each queued entry carries a command code, a source tag, an order number, a ready time and a marked-pending bit. Entries leave from the front in the order they arrived. Next to the queue, the block keeps two sticky summary flags. One, `need_excl`, records that a non-snoop request needing an exclusive copy was queued. The other, `has_upg`, records that a non-snoop upgrade-class request was queued.

When the surrounding miss logic learns that the line it holds is about to be taken away, it pulses `rewrite`. In that same clock cycle, every queued upgrade-class command is turned into its fallback form. A plain upgrade becomes a read-exclusive. A conditional-store upgrade becomes its failed form. A conditional store becomes its failed form. The rewrite runs only while `has_upg` is set, and it clears that flag.

The miss logic pulses `flag_clr` when it retires the miss with an empty queue, which readies the flags for the next miss.

Top module: `mtq_target_list`

## Requirements
- R1: After a synchronous reset, the block shows `empty`=1, `full`=0, `count`=0, `need_excl`=0, `has_upg`=0 and `push_err`=0.
- R2: Popped entries leave in push order. Each entry returns the cmd, src, order, ready time and mark bit that were pushed, on the head outputs. A push and a pop in the same cycle leave the count unchanged.
- R3: `full` is 1 when `count` equals DEPTH. A push while full is dropped, the contents and count do not change, and `push_err` is 1 for exactly the cycle after that push.
- R4: Command codes are: 0 read-shared, 1 read-exclusive, 2 upgrade, 3 conditional-store upgrade, 4 failed conditional-store upgrade, 5 conditional store, 6 failed conditional store, 7 write, 8 prefetch; 9..15 are other. An accepted push whose src is not snoop and whose cmd is in 1..7 sets `need_excl`.
- R5: An accepted push whose src is not snoop and whose cmd is 2, 3 or 5 sets `has_upg`.
- R6: Source tags are 0 CPU, 1 snoop, 2 prefetcher. A push with src 1 changes neither summary flag.
- R7: A `rewrite` while `has_upg`=1 maps, in one cycle and for every queued entry of any source, cmd 2 to 1, cmd 3 to 4 and cmd 5 to 6. All other codes are left unchanged. An entry pushed in the same cycle is stored as given.
- R8: A `rewrite` while `has_upg`=0 changes no queued command.
- R9: After a `rewrite` with `has_upg`=1, `has_upg` is 0 unless a push in that same cycle sets it again. `need_excl` is not affected by a rewrite.
- R10: `flag_clr` clears both summary flags. It is legal only while the queue is empty.
- R11: Both flags are sticky. Popping entries, including draining the queue, does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Enqueue a request this cycle |
| push_cmd | input | 4 | Command code of the pushed request |
| push_src | input | 2 | Source tag of the pushed request |
| push_order | input | ORDER_W | Order number of the pushed request |
| push_time | input | TIME_W | Ready time of the pushed request |
| push_mark | input | 1 | Marked-pending bit of the pushed request |
| pop | input | 1 | Remove the head entry |
| rewrite | input | 1 | Bulk rewrite strobe for upgrade-class commands |
| flag_clr | input | 1 | Clear both summary flags |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| count | output | CNT_W | Number of queued entries |
| head_cmd | output | 4 | Command of the head entry |
| head_src | output | 2 | Source tag of the head entry |
| head_order | output | ORDER_W | Order number of the head entry |
| head_time | output | TIME_W | Ready time of the head entry |
| head_mark | output | 1 | Marked-pending bit of the head entry |
| need_excl | output | 1 | Summary flag: a queued non-snoop request needs exclusivity |
| has_upg | output | 1 | Summary flag: a non-snoop upgrade-class request was queued |
| push_err | output | 1 | Pulses after a push was dropped because the queue was full |

## Verification
The checker takes two things for granted about the inputs. First, `pop` is never raised while the queue is empty. Second, `flag_clr` is raised only while the queue is empty. Both are stated as assertions on the inputs, and the bench keeps to them: it pops only entries that it has itself counted into the queue, and it issues every flag clear between miss episodes, after a full drain. The flag-stability and rewrite-clearing properties also assume that no push or flag clear shares the cycle. The bench exercises those overlaps only in dedicated checks, where the expected outcome is worked out by hand.

// File: rtl/mtq_pkg.sv
package mtq_pkg;

  localparam int CMD_W = 4;
  localparam int SRC_W = 2;

  typedef logic [CMD_W-1:0] cmd_t;

  localparam cmd_t CMD_RD_SHR     = 4'd0;
  localparam cmd_t CMD_RD_EXCL    = 4'd1;
  localparam cmd_t CMD_UPG        = 4'd2;
  localparam cmd_t CMD_SC_UPG     = 4'd3;
  localparam cmd_t CMD_SC_UPG_NAK = 4'd4;
  localparam cmd_t CMD_SC         = 4'd5;
  localparam cmd_t CMD_SC_NAK     = 4'd6;
  localparam cmd_t CMD_WRITE      = 4'd7;
  localparam cmd_t CMD_PREFETCH   = 4'd8;

  typedef enum logic [SRC_W-1:0] {
    SRC_CPU   = 2'd0,
    SRC_SNOOP = 2'd1,
    SRC_PF    = 2'd2
  } src_t;

  // Commands that require an exclusive copy of the line.
  function automatic logic cmd_needs_excl(input cmd_t c);
    case (c)
      CMD_RD_EXCL, CMD_UPG, CMD_SC_UPG, CMD_SC_UPG_NAK,
      CMD_SC, CMD_SC_NAK, CMD_WRITE: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

  // Commands that rely on a still-valid copy and must be rewritten if it is lost.
  function automatic logic cmd_is_upg(input cmd_t c);
    return (c == CMD_UPG) || (c == CMD_SC_UPG) || (c == CMD_SC);
  endfunction

  // Fallback form of an upgrade-class command; identity for all others.
  function automatic cmd_t cmd_fallback(input cmd_t c);
    case (c)
      CMD_UPG:    return CMD_RD_EXCL;
      CMD_SC_UPG: return CMD_SC_UPG_NAK;
      CMD_SC:     return CMD_SC_NAK;
      default:    return c;
    endcase
  endfunction

endpackage

// File: rtl/mtq_slot.sv
module mtq_slot
  import mtq_pkg::*;
#(
  parameter int ORDER_W = 16,
  parameter int TIME_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  cmd_t               wr_cmd,
  input  logic [SRC_W-1:0]   wr_src,
  input  logic [ORDER_W-1:0] wr_order,
  input  logic [TIME_W-1:0]  wr_time,
  input  logic               wr_mark,
  input  logic               rw_en,
  output cmd_t               q_cmd,
  output logic [SRC_W-1:0]   q_src,
  output logic [ORDER_W-1:0] q_order,
  output logic [TIME_W-1:0]  q_time,
  output logic               q_mark
);

  // A write wins over a rewrite, so a same-cycle push is stored as given.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_cmd <= CMD_RD_SHR;
      q_src <= SRC_CPU;
    end else if (wr_en) begin
      q_cmd <= wr_cmd;
      q_src <= wr_src;
    end else if (rw_en) begin
      q_cmd <= cmd_fallback(q_cmd);
    end
  end

  // Payload fields need no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      q_order <= wr_order;
      q_time  <= wr_time;
      q_mark  <= wr_mark;
    end
  end

endmodule

// File: rtl/mtq_ptr_ctrl.sv
module mtq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_ok,
  input  logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count_nxt;

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok) count_nxt = count + 1'b1;
    if (pop_ok && !push_ok) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count_nxt;
      full  <= (count_nxt == CNT_W'(DEPTH));
      empty <= (count_nxt == '0);
    end
  end

endmodule

// File: rtl/mtq_flag_unit.sv
module mtq_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic set_excl,
  input  logic set_upg,
  input  logic rewrite,
  input  logic flag_clr,
  output logic need_excl,
  output logic has_upg,
  output logic do_rewrite
);

  // A rewrite acts only while an upgrade is recorded.
  assign do_rewrite = rewrite && has_upg;

  always_ff @(posedge clk) begin
    if (rst) begin
      need_excl <= 1'b0;
      has_upg   <= 1'b0;
    end else begin
      need_excl <= (need_excl && !flag_clr) || set_excl;
      has_upg   <= (has_upg && !flag_clr && !do_rewrite) || set_upg;
    end
  end

endmodule

// File: rtl/mtq_target_list.sv
module mtq_target_list
  import mtq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ORDER_W = 16,
  parameter int TIME_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push_valid,
  input  logic [3:0]         push_cmd,
  input  logic [1:0]         push_src,
  input  logic [ORDER_W-1:0] push_order,
  input  logic [TIME_W-1:0]  push_time,
  input  logic               push_mark,
  input  logic               pop,
  input  logic               rewrite,
  input  logic               flag_clr,
  output logic               full,
  output logic               empty,
  output logic [CNT_W-1:0]   count,
  output logic [3:0]         head_cmd,
  output logic [1:0]         head_src,
  output logic [ORDER_W-1:0] head_order,
  output logic [TIME_W-1:0]  head_time,
  output logic               head_mark,
  output logic               need_excl,
  output logic               has_upg,
  output logic               push_err
);

  logic             push_ok, pop_ok, from_snoop, do_rewrite;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  cmd_t               s_cmd   [DEPTH];
  logic [SRC_W-1:0]   s_src   [DEPTH];
  logic [ORDER_W-1:0] s_order [DEPTH];
  logic [TIME_W-1:0]  s_time  [DEPTH];
  logic               s_mark  [DEPTH];

  assign push_ok    = push_valid && !full;
  assign pop_ok     = pop && !empty;
  assign from_snoop = (push_src == SRC_SNOOP);

  mtq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  mtq_flag_unit u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_excl   (push_ok && !from_snoop && cmd_needs_excl(push_cmd)),
    .set_upg    (push_ok && !from_snoop && cmd_is_upg(push_cmd)),
    .rewrite    (rewrite),
    .flag_clr   (flag_clr),
    .need_excl  (need_excl),
    .has_upg    (has_upg),
    .do_rewrite (do_rewrite)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    mtq_slot #(.ORDER_W(ORDER_W), .TIME_W(TIME_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (push_ok && (wr_ptr == PTR_W'(i))),
      .wr_cmd   (push_cmd),
      .wr_src   (push_src),
      .wr_order (push_order),
      .wr_time  (push_time),
      .wr_mark  (push_mark),
      .rw_en    (do_rewrite),
      .q_cmd    (s_cmd[i]),
      .q_src    (s_src[i]),
      .q_order  (s_order[i]),
      .q_time   (s_time[i]),
      .q_mark   (s_mark[i])
    );
  end

  assign head_cmd   = s_cmd[rd_ptr];
  assign head_src   = s_src[rd_ptr];
  assign head_order = s_order[rd_ptr];
  assign head_time  = s_time[rd_ptr];
  assign head_mark  = s_mark[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) push_err <= 1'b0;
    else     push_err <= push_valid && full;
  end

endmodule

// File: rtl/mtq_checker.sv
module mtq_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push_valid,
  input logic             pop,
  input logic             rewrite,
  input logic             flag_clr,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       head_cmd,
  input logic             need_excl,
  input logic             has_upg,
  input logic             push_err
);

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> empty && !full && !has_upg && !need_excl); // R1
  AST_HOLD_COUNT:  assert property (@(posedge clk) disable iff (rst) !push_valid && !pop |=> $stable(count)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) full && push_valid && !pop |=> full && push_err); // R3
  AST_ERR_CAUSE:   assert property (@(posedge clk) disable iff (rst) push_err |-> $past(full && push_valid)); // R3
  AST_FULL_COUNT:  assert property (@(posedge clk) disable iff (rst) full |-> count == CNT_W'(DEPTH)); // R3
  AST_RW_IDLE:     assert property (@(posedge clk) disable iff (rst) rewrite && !has_upg && !pop && !push_valid && !empty |=> $stable(head_cmd)); // R8
  AST_RW_CLEARS:   assert property (@(posedge clk) disable iff (rst) rewrite && has_upg && !push_valid |=> !has_upg); // R9
  AST_RW_EXCL:     assert property (@(posedge clk) disable iff (rst) rewrite && !flag_clr && !push_valid |=> $stable(need_excl)); // R9
  AST_CLR_EMPTY:   assert property (@(posedge clk) disable iff (rst) flag_clr |-> empty); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) need_excl && !flag_clr |=> need_excl); // R11
  AST_POP_LEGAL:   assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R2

endmodule

bind mtq_target_list mtq_checker #(.DEPTH(DEPTH)) u_mtq_checker (
  .clk        (clk),
  .rst        (rst),
  .push_valid (push_valid),
  .pop        (pop),
  .rewrite    (rewrite),
  .flag_clr   (flag_clr),
  .full       (full),
  .empty      (empty),
  .count      (count),
  .head_cmd   (head_cmd),
  .need_excl  (need_excl),
  .has_upg    (has_upg),
  .push_err   (push_err)
);

// File: tb/mtq_target_list_bench.sv
`timescale 1ns/1ps
module mtq_target_list_bench;

  localparam int DEPTH = 4;
  localparam int OW = 8;
  localparam int TW = 12;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 0, push_mark = 0, pop = 0, rewrite = 0, flag_clr = 0;
  logic [3:0] push_cmd = 0;
  logic [1:0] push_src = 0;
  logic [OW-1:0] push_order = 0;
  logic [TW-1:0] push_time = 0;
  logic full, empty, head_mark, need_excl, has_upg, push_err;
  logic [CW-1:0] count;
  logic [3:0] head_cmd;
  logic [1:0] head_src;
  logic [OW-1:0] head_order;
  logic [TW-1:0] head_time;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mtq_target_list #(.DEPTH(DEPTH), .ORDER_W(OW), .TIME_W(TW)) u_mtq_target_list (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_cmd(push_cmd),
    .push_src(push_src), .push_order(push_order), .push_time(push_time),
    .push_mark(push_mark), .pop(pop), .rewrite(rewrite), .flag_clr(flag_clr),
    .full(full), .empty(empty), .count(count), .head_cmd(head_cmd),
    .head_src(head_src), .head_order(head_order), .head_time(head_time),
    .head_mark(head_mark), .need_excl(need_excl), .has_upg(has_upg),
    .push_err(push_err)
  );

  function automatic bit x_excl(int c); return c >= 1 && c <= 7; endfunction
  function automatic bit x_upg(int c); return c == 2 || c == 3 || c == 5; endfunction
  function automatic int x_fb(int c);
    return (c == 2) ? 1 : (c == 3) ? 4 : (c == 5) ? 6 : c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    push_valid = 0; pop = 0; rewrite = 0; flag_clr = 0;
  endtask

  task automatic do_push(input int c, input int s, input int o, input int t, input bit m);
    push_valid = 1; push_cmd = 4'(c); push_src = 2'(s);
    push_order = OW'(o); push_time = TW'(t); push_mark = m;
    cyc(); idle();
  endtask

  task automatic do_pop();
    pop = 1; cyc(); idle();
  endtask

  task automatic do_clr();
    flag_clr = 1; cyc(); idle();
  endtask

  task automatic do_rw();
    rewrite = 1; cyc(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk(empty == 1, "R1 empty", int'(empty), 1);
    chk(full == 0, "R1 full", int'(full), 0);
    chk(count == 0, "R1 count", int'(count), 0);
    chk(need_excl == 0 && has_upg == 0, "R1 flags", int'({need_excl, has_upg}), 0);
    chk(push_err == 0, "R1 push_err", int'(push_err), 0);

    // Sweep: every command from every source, flags and head fields (R2 R4 R5 R6)
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 3; s++) begin
        do_clr();
        do_push(c, s, c * 3 + s, c * 7 + s + 100, 1'((c + s) & 1));
        chk(need_excl == ((s != 1) && x_excl(c)), "R4 R6 need_excl", int'(need_excl), int'((s != 1) && x_excl(c)));
        chk(has_upg == ((s != 1) && x_upg(c)), "R5 R6 has_upg", int'(has_upg), int'((s != 1) && x_upg(c)));
        chk(head_cmd == 4'(c) && head_src == 2'(s), "R2 head cmd/src", int'({head_cmd, head_src}), (c << 2) | s);
        chk(head_order == OW'(c * 3 + s) && head_time == TW'(c * 7 + s + 100) && head_mark == 1'((c + s) & 1),
            "R2 head order/time/mark", int'(head_order), c * 3 + s);
        do_pop();
        chk(empty == 1, "R2 drained", int'(empty), 1);
      end
    end

    // Sweep: rewrite per command (R7 R8 R9)
    for (int c = 0; c < 16; c++) begin
      do_clr();
      do_push(c, 1, 0, 0, 0);
      do_rw();
      chk(head_cmd == 4'(c), "R8 no rewrite with flag clear", int'(head_cmd), c);
      do_push(c, 0, 1, 0, 0);
      do_rw();
      chk(has_upg == 0, "R9 has_upg cleared", int'(has_upg), 0);
      chk(need_excl == x_excl(c), "R9 need_excl kept", int'(need_excl), int'(x_excl(c)));
      chk(head_cmd == 4'(x_upg(c) ? x_fb(c) : c), "R7 snoop entry rewrite", int'(head_cmd), x_upg(c) ? x_fb(c) : c);
      do_pop();
      chk(head_cmd == 4'(x_upg(c) ? x_fb(c) : c), "R7 cpu entry rewrite", int'(head_cmd), x_upg(c) ? x_fb(c) : c);
      do_pop();
    end

    // Overflow and ordering (R3 R2 R11)
    do_clr();
    do_push(0, 0, 10, 1, 0);
    do_push(7, 0, 11, 2, 1);
    do_push(2, 2, 12, 3, 0);
    do_push(8, 1, 13, 4, 1);
    chk(full == 1 && count == CW'(DEPTH), "R3 full at depth", int'(count), DEPTH);
    chk(push_err == 0, "R3 no error before overflow", int'(push_err), 0);
    do_push(3, 0, 99, 5, 0);
    chk(push_err == 1, "R3 push_err pulse", int'(push_err), 1);
    chk(count == CW'(DEPTH), "R3 count held", int'(count), DEPTH);
    cyc();
    chk(push_err == 0, "R3 push_err one cycle", int'(push_err), 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk(head_order == OW'(10 + k), "R2 pop order", int'(head_order), 10 + k);
      do_pop();
    end
    chk(empty == 1, "R2 empty after drain", int'(empty), 1);
    chk(need_excl == 1 && has_upg == 1, "R11 flags sticky", int'({need_excl, has_upg}), 3);
    do_rw();
    chk(has_upg == 0 && need_excl == 1, "R9 rewrite on empty", int'({need_excl, has_upg}), 2);
    do_clr();
    chk(need_excl == 0 && has_upg == 0, "R10 flag clear", int'({need_excl, has_upg}), 0);

    // Simultaneous push and pop (R2)
    do_push(1, 0, 20, 0, 0);
    push_valid = 1; push_cmd = 4'd0; push_src = 2'd0; push_order = OW'(21); pop = 1;
    cyc(); idle();
    chk(count == 1, "R2 push+pop count", int'(count), 1);
    chk(head_order == OW'(21), "R2 push+pop head", int'(head_order), 21);
    do_pop();

    // Rewrite in the same cycle as an upgrade push (R7 R9)
    do_clr();
    do_push(5, 0, 30, 0, 0);
    push_valid = 1; push_cmd = 4'd2; push_src = 2'd0; push_order = OW'(31); rewrite = 1;
    cyc(); idle();
    chk(has_upg == 1, "R9 same-cycle push re-sets has_upg", int'(has_upg), 1);
    chk(head_cmd == 4'd6, "R7 existing entry rewritten", int'(head_cmd), 6);
    do_pop();
    chk(head_cmd == 4'd2, "R7 same-cycle push stored as given", int'(head_cmd), 2);
    do_pop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule